// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address sequence for a four-beat burst into a synchronous memory. A burst opens when one of two start strobes is sampled low. The block then captures a 16-bit external address. While the burst runs, the upper fourteen bits stay fixed. The low two bits step through the four beats in one of two orders.

A static ordering pin picks the order. In interleaved order the beat count is XORed into the captured low bits. In linear order the beat count is added to the captured low bits, modulo 4. An active-low advance input moves the burst forward one beat. When advance is high the burst is suspended and the address is held.

The two strobes are qualified differently. The processor-side strobe counts only while the active-low chip select is asserted. The controller-side strobe always counts.

Both outputs are registered. They show the result of a clock edge's sampled inputs right after that edge.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset clears `burst_addr` and `beat_idx` to zero. It takes priority over every other input.
- R2: When `ctrl_strobe_n` is sampled low, the next `burst_addr` equals the sampled `addr_in` and `beat_idx` becomes 0. This holds whatever the state of `chip_sel_n`.
- R3: When `proc_strobe_n` is sampled low while `chip_sel_n` is high, and `ctrl_strobe_n` is high, the strobe is ignored. The cycle acts as a plain advance cycle or suspend cycle, according to `adv_n`.
- R4: With `order_linear` = 0, the low bits are the captured start bits XOR `beat_idx`. A start of 01 therefore gives 01, 00, 11, 10.
- R5: With `order_linear` = 1, the low bits are the captured start bits plus `beat_idx`, modulo 4. A start of 10 therefore gives 10, 11, 00, 01.
- R6: When no start is qualified and `adv_n` is sampled low, `beat_idx` increments by one.
- R7: When no start is qualified and `adv_n` is sampled high, both `burst_addr` and `beat_idx` hold.
- R8: Bits [15:2] of `burst_addr` change only on a qualified start. Neither later values of `addr_in` nor a wrap of the low bits moves them.
- R9: An advance from beat 3 returns `beat_idx` to 0, and the low bits return to the captured start bits.
- R10: A qualified start takes priority over an advance sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | 16 | External start address |
| proc_strobe_n | input | 1 | Processor-side start strobe, active low, gated by chip select |
| ctrl_strobe_n | input | 1 | Controller-side start strobe, active low, never gated |
| adv_n | input | 1 | Burst advance, active low; high suspends the burst |
| chip_sel_n | input | 1 | Primary chip select, active low; qualifies only the processor strobe |
| order_linear | input | 1 | Static ordering pin: 1 = linear, 0 = interleaved |
| burst_addr | output | 16 | Registered current burst address |
| beat_idx | output | 2 | Registered beat number within the burst (0 to 3) |

## Verification
The bench targets these corner cases:
- **Wrap after beat 3, in both orders.** A design that stops at beat 3 would leave the address stuck. A design that wraps to 00 would return to beat-0 bits other than the start.
- **Linear start of 11.** Here the low bits roll over to 00. A design that lets the carry reach bit 2 would corrupt the upper address.
- **Processor strobe with chip select inactive.** A design missing the mask would reload the address. A design that masks too much would also block the advance in that cycle.
- **Controller strobe together with an active advance.** A wrong priority would step the old burst instead of starting the new one.
- **Reset in the middle of a burst.**

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORDER_INTERLEAVE = 1'b0,
    ORDER_LINEAR     = 1'b1
  } order_e;

  typedef struct packed {
    logic load;
    logic step;
  } seq_cmd_t;

endpackage

// File: rtl/burst_strobe_qual.sv
module burst_strobe_qual
  import burst_seq_pkg::*;
(
  input  logic     proc_strobe_n,
  input  logic     ctrl_strobe_n,
  input  logic     adv_n,
  input  logic     chip_sel_n,
  output seq_cmd_t cmd
);

  logic proc_start;
  logic ctrl_start;

  always_comb begin
    proc_start = ~proc_strobe_n & ~chip_sel_n;
    ctrl_start = ~ctrl_strobe_n;
    cmd.load   = proc_start | ctrl_start;
    cmd.step   = ~cmd.load & ~adv_n;
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] start_in,
  output logic [CNT_W-1:0] start_nxt,
  output logic [CNT_W-1:0] beat_nxt,
  output logic [CNT_W-1:0] beat_q
);

  logic [CNT_W-1:0] start_q;

  always_comb begin
    start_nxt = start_q;
    beat_nxt  = beat_q;
    if (load) begin
      start_nxt = start_in;
      beat_nxt  = '0;
    end else if (step) begin
      beat_nxt = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else begin
      start_q <= start_nxt;
      beat_q  <= beat_nxt;
    end
  end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_bits,
  input  logic [CNT_W-1:0] beat,
  input  order_e           order,
  output logic [CNT_W-1:0] low_bits
);

  logic [CNT_W-1:0] ilv_bits;
  logic [CNT_W-1:0] lin_bits;

  for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
    assign ilv_bits[b] = start_bits[b] ^ beat[b];
  end

  assign lin_bits = start_bits + beat;

  always_comb begin
    low_bits = (order == ORDER_LINEAR) ? lin_bits : ilv_bits;
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              adv_n,
  input  logic              chip_sel_n,
  input  logic              order_linear,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [CNT_W-1:0]  beat_idx
);

  localparam int HI_W = ADDR_W - CNT_W;

  seq_cmd_t         cmd;
  logic [CNT_W-1:0] start_nxt;
  logic [CNT_W-1:0] beat_nxt;
  logic [CNT_W-1:0] low_nxt;
  logic [HI_W-1:0]  hi_q;
  logic [HI_W-1:0]  hi_nxt;
  logic [CNT_W-1:0] low_q;
  order_e           order;

  assign order = order_e'(order_linear);

  burst_strobe_qual u_qual (
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .chip_sel_n    (chip_sel_n),
    .cmd           (cmd)
  );

  burst_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (cmd.load),
    .step      (cmd.step),
    .start_in  (addr_in[CNT_W-1:0]),
    .start_nxt (start_nxt),
    .beat_nxt  (beat_nxt),
    .beat_q    (beat_idx)
  );

  burst_order_map #(.CNT_W(CNT_W)) u_map (
    .start_bits (start_nxt),
    .beat       (beat_nxt),
    .order      (order),
    .low_bits   (low_nxt)
  );

  assign hi_nxt = cmd.load ? addr_in[ADDR_W-1:CNT_W] : hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      low_q <= '0;
    end else begin
      hi_q  <= hi_nxt;
      low_q <= low_nxt;
    end
  end

  assign burst_addr = {hi_q, low_q};

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_strobe_n |=> (burst_addr == $past(addr_in)) && (beat_idx == '0));

  // R3
  proc_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_strobe_n && !proc_strobe_n && chip_sel_n && adv_n)
      |=> $stable(burst_addr) && $stable(beat_idx));

  // R6
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_strobe_n && (proc_strobe_n || chip_sel_n) && !adv_n)
      |=> beat_idx == CNT_W'($past(beat_idx) + 1'b1));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_strobe_n && (proc_strobe_n || chip_sel_n) && adv_n)
      |=> $stable(burst_addr) && $stable(beat_idx));

  // R8
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_strobe_n && (proc_strobe_n || chip_sel_n))
      |=> $stable(burst_addr[ADDR_W-1:CNT_W]));

  // R5
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (order_linear && ctrl_strobe_n && (proc_strobe_n || chip_sel_n) && !adv_n)
      |=> burst_addr[CNT_W-1:0] == CNT_W'($past(burst_addr[CNT_W-1:0]) + 1'b1));

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] addr_in;
  logic        proc_strobe_n;
  logic        ctrl_strobe_n;
  logic        adv_n;
  logic        chip_sel_n;
  logic        order_linear;
  logic [15:0] burst_addr;
  logic [1:0]  beat_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk           (clk),
    .rst           (rst),
    .addr_in       (addr_in),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .chip_sel_n    (chip_sel_n),
    .order_linear  (order_linear),
    .burst_addr    (burst_addr),
    .beat_idx      (beat_idx)
  );

  // Vector layout: req[42:39] c p s a m [38:34] addr[33:18] exp_addr[17:2] exp_beat[1:0]
  localparam int NV = 20;
  localparam logic [42:0] TBL [NV] = '{
    {4'd2,  5'b01110, 16'h1235, 16'h1235, 2'd0},
    {4'd4,  5'b11100, 16'hFFFF, 16'h1234, 2'd1},
    {4'd4,  5'b11100, 16'hFFFF, 16'h1237, 2'd2},
    {4'd7,  5'b11110, 16'hFFFF, 16'h1237, 2'd2},
    {4'd4,  5'b11100, 16'hFFFF, 16'h1236, 2'd3},
    {4'd9,  5'b11100, 16'hFFFF, 16'h1235, 2'd0},
    {4'd5,  5'b10011, 16'hABCE, 16'hABCE, 2'd0},
    {4'd5,  5'b11101, 16'h0000, 16'hABCF, 2'd1},
    {4'd5,  5'b11101, 16'h0000, 16'hABCC, 2'd2},
    {4'd3,  5'b10111, 16'h5555, 16'hABCC, 2'd2},
    {4'd5,  5'b11101, 16'h0000, 16'hABCD, 2'd3},
    {4'd9,  5'b11101, 16'h0000, 16'hABCE, 2'd0},
    {4'd10, 5'b01100, 16'h0F03, 16'h0F03, 2'd0},
    {4'd4,  5'b11100, 16'h1111, 16'h0F02, 2'd1},
    {4'd4,  5'b11100, 16'h1111, 16'h0F01, 2'd2},
    {4'd4,  5'b11100, 16'h1111, 16'h0F00, 2'd3},
    {4'd2,  5'b01111, 16'h8003, 16'h8003, 2'd0},
    {4'd8,  5'b11101, 16'h7FFF, 16'h8000, 2'd1},
    {4'd5,  5'b11101, 16'h7FFF, 16'h8001, 2'd2},
    {4'd5,  5'b11101, 16'h7FFF, 16'h8002, 2'd3}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] ea, input logic [1:0] eb);
    checks++;
    if (burst_addr !== ea || beat_idx !== eb) begin
      fails++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, burst_addr, beat_idx, ea, eb);
    end
  endtask

  task automatic drive(input logic c, input logic p, input logic s,
                       input logic a, input logic m, input logic [15:0] ad);
    ctrl_strobe_n = c;
    proc_strobe_n = p;
    chip_sel_n    = s;
    adv_n         = a;
    order_linear  = m;
    addr_in       = ad;
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000);
    repeat (2) @(negedge clk);
    check("R1", 16'h0000, 2'd0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i][38], TBL[i][37], TBL[i][36], TBL[i][35], TBL[i][34], TBL[i][33:18]);
      @(negedge clk);
      // R4 R5 R6 R7 R8 R9 R10 per vector tag
      check(req_name(TBL[i][42:39]), TBL[i][17:2], TBL[i][1:0]);
    end
    // R2: controller strobe mid-burst, then reset clears (R1)
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h7777);
    @(negedge clk);
    check("R2", 16'h7777, 2'd0);
    rst = 1'b1;
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h4444);
    @(negedge clk);
    check("R1", 16'h0000, 2'd0);
    rst = 1'b0;
    // R3: masked processor strobe still lets the advance through (R6)
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h9999);
    @(negedge clk);
    check("R3", 16'h0001, 2'd1);
    // R7: suspend holds
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h2222);
    @(negedge clk);
    check("R7", 16'h0001, 2'd1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule